// File: doc/BRIEF.md
# I2C Bit-Clock Timing Generator

This block times single bits on an I2C bus for a master. Counts are given in peripheral-clock cycles. For each bit that the byte engine requests, it drives SCL low for a programmed low phase and then releases it. It waits until the bus line is seen high, which lets a slave stretch the clock, and then holds the high phase for a programmed count. Inside the low phase it raises a strobe that tells the byte engine when to change SDA. That strobe honours a programmable hold delay after the SCL fall and a programmable setup interval before the SCL rise.

Two pairs of high/low counts exist, one for standard speed and one for fast speed, and a two-bit speed field picks the pair. Each count has a floor: the high count never goes below 6 and the low count never goes below 8. Software writes the counts only while the generator is disabled. The block copies them into shadow registers at that time, so values changed during operation have no effect until the next enable. Computing the counts from a bus frequency is left to software.

Top module: `i2c_tgen`

## Requirements
- R1: While reset is held or `en_i` is low, `scl_o` is 1 (released) and `sda_upd_o` and `bit_done_o` stay 0. Dropping `en_i` in the middle of a bit releases SCL in the next cycle and aborts the bit without a bit-done pulse. `bit_req_i` is ignored while disabled.
- R2: `speed_i[2]` set with `speed_i[1]` clear selects the fast pair (`fast_hcnt_i`/`fast_lcnt_i`). Every other value (`speed_i[1]` set, both bits set, or neither) selects the standard pair (`std_hcnt_i`/`std_lcnt_i`).
- R3: The effective high count H is the selected high count, or 6 if that count is smaller.
- R4: The effective low count is the selected low count, or 8 if that count is smaller.
- R5: When `hold_i[8]` is 1, `sda_upd_o` pulses once per low phase, in low cycle index `hold_i[7:0]+1` (index 0 is the first cycle with SCL low).
- R6: When `hold_i[8]` is 0, `sda_upd_o` pulses in low cycle index 0, whatever the value of `hold_i[7:0]`.
- R7: Let s = `setup_i`−1, with a setup value of 0 treated as 1. Let h be the strobe index from R5 or R6. The low phase then lasts L = max(effective low count, h+s+1) cycles, so that at least s cycles separate the strobe from the SCL rise.
- R8: SCL stays released for H+2+N cycles. Here N is the number of cycles after release during which an external device holds the SCL line low. The 2 cycles are the line-sense latency.
- R9: `bit_done_o` pulses exactly once per bit, in the last released cycle. SCL goes low in the following cycle.
- R10: The speed field, all four phase counts, the setup count and the hold field are captured only while `en_i` is low. Changes made while enabled have no effect on the bit timing.
- R11: If `bit_req_i` is high in the bit-done cycle, the next low phase starts at once. Otherwise SCL is parked low and no strobes occur until the next request or until the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Generator enable; configuration is captured while low |
| speed_i | input | 2 | Speed select, bits [2:1]: bit 1 standard, bit 2 fast |
| std_hcnt_i | input | 16 | Standard-speed high-phase count |
| std_lcnt_i | input | 16 | Standard-speed low-phase count |
| fast_hcnt_i | input | 16 | Fast-speed high-phase count |
| fast_lcnt_i | input | 16 | Fast-speed low-phase count |
| setup_i | input | 8 | SDA setup count (1 to 255; 0 treated as 1) |
| hold_i | input | 9 | Bit 8 hold enable, bits [7:0] SDA hold count |
| bit_req_i | input | 1 | Byte engine requests a bit (level, sampled at bit end) |
| scl_i | input | 1 | Sensed SCL bus line |
| scl_o | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sda_upd_o | output | 1 | Strobe: byte engine may change SDA now |
| bit_done_o | output | 1 | One pulse at the end of each bit |

## Verification
The scoreboard predicts, for every bit, the low-phase length, the strobe index and the high-phase length, and compares all three against what is observed at the ports. Clamp settings below 6 and 8 catch a generator that uses the raw counts, which would give short phases. A large setup with an enabled hold catches a generator that leaves the low phase at its programmed length, which would push the SCL rise right up against the data change. Setup 0 catches a wrapped decrement. A cleared hold enable with a nonzero hold count catches a strobe that comes late. Stretch cycles catch a high phase that starts counting before the line is really high, which would show up as a high phase that is too short. Counts rewritten while enabled catch a generator without shadow registers, whose timing would change in the middle of a transfer. The speed codes 01, 10, 11 and 00 catch a wrong priority between the two speed bits.

// File: rtl/i2c_tgen_pkg.sv
package i2c_tgen_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_WAIT, ST_HIGH} tg_state_e;
  localparam int STD_BIT  = 1;
  localparam int FAST_BIT = 2;
endpackage

// File: rtl/i2c_tgen_sync.sv
module i2c_tgen_sync #(
  parameter int STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_one
      logic r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= 1'b1;
        else         r_q <= d_i;
      end
      assign q_o = r_q;
    end else begin : g_chain
      logic [STAGES-1:0] r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '1;
        else         r_q <= {r_q[STAGES-2:0], d_i};
      end
      assign q_o = r_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2c_tgen_cfg.sv
module i2c_tgen_cfg
  import i2c_tgen_pkg::*;
#(
  parameter int CW       = 16,
  parameter int SW       = 8,
  parameter int MIN_HIGH = 6,
  parameter int MIN_LOW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [2:1]    speed_i,
  input  logic [CW-1:0] std_hcnt_i,
  input  logic [CW-1:0] std_lcnt_i,
  input  logic [CW-1:0] fast_hcnt_i,
  input  logic [CW-1:0] fast_lcnt_i,
  input  logic [SW-1:0] setup_i,
  input  logic [SW:0]   hold_i,
  output logic [CW-1:0] high_len_o,
  output logic [CW-1:0] low_len_o,
  output logic [CW-1:0] upd_at_o
);
  localparam logic [CW-1:0] MIN_H = CW'(MIN_HIGH);
  localparam logic [CW-1:0] MIN_L = CW'(MIN_LOW);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [2:1]    spd_q;
  logic [CW-1:0] sh_q, sl_q, fh_q, fl_q;
  logic [SW-1:0] su_q;
  logic [SW:0]   hd_q;

  // shadow copy, frozen while the generator runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spd_q <= '0;
      sh_q  <= '0;
      sl_q  <= '0;
      fh_q  <= '0;
      fl_q  <= '0;
      su_q  <= '0;
      hd_q  <= '0;
    end else if (load_i) begin
      spd_q <= speed_i;
      sh_q  <= std_hcnt_i;
      sl_q  <= std_lcnt_i;
      fh_q  <= fast_hcnt_i;
      fl_q  <= fast_lcnt_i;
      su_q  <= setup_i;
      hd_q  <= hold_i;
    end
  end

  logic          use_fast;
  logic [CW-1:0] h_sel, l_sel, h_eff, l_eff, hold_len, setup_len, need;

  always_comb begin
    use_fast  = spd_q[FAST_BIT] & ~spd_q[STD_BIT];
    h_sel     = use_fast ? fh_q : sh_q;
    l_sel     = use_fast ? fl_q : sl_q;
    h_eff     = (h_sel < MIN_H) ? MIN_H : h_sel;
    l_eff     = (l_sel < MIN_L) ? MIN_L : l_sel;
    hold_len  = hd_q[SW] ? (CW'(hd_q[SW-1:0]) + ONE) : '0;
    setup_len = (su_q == '0) ? '0 : (CW'(su_q) - ONE);
    need      = hold_len + setup_len + ONE;
  end

  assign high_len_o = h_eff;
  assign low_len_o  = (l_eff < need) ? need : l_eff;
  assign upd_at_o   = hold_len;
endmodule

// File: rtl/i2c_tgen_phase.sv
module i2c_tgen_phase #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic [CW-1:0] limit_i,
  output logic [CW-1:0] cnt_o,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o = cnt_q;
  assign hit_o = run_i && (cnt_q == limit_i - CW'(1));
endmodule

// File: rtl/i2c_tgen.sv
module i2c_tgen
  import i2c_tgen_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SW          = 8,
  parameter int MIN_HIGH    = 6,
  parameter int MIN_LOW     = 8,
  parameter int SYNC_STAGES = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [2:1]    speed_i,
  input  logic [CW-1:0] std_hcnt_i,
  input  logic [CW-1:0] std_lcnt_i,
  input  logic [CW-1:0] fast_hcnt_i,
  input  logic [CW-1:0] fast_lcnt_i,
  input  logic [SW-1:0] setup_i,
  input  logic [SW:0]   hold_i,
  input  logic          bit_req_i,
  input  logic          scl_i,
  output logic          scl_o,
  output logic          sda_upd_o,
  output logic          bit_done_o
);
  logic          scl_seen;
  logic [CW-1:0] high_len, low_len, upd_at, limit, cnt;
  logic          run, clr, hit;
  tg_state_e     st_q;
  logic          parked_q;

  i2c_tgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (scl_i),
    .q_o    (scl_seen)
  );

  i2c_tgen_cfg #(
    .CW(CW), .SW(SW), .MIN_HIGH(MIN_HIGH), .MIN_LOW(MIN_LOW)
  ) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (!en_i),
    .speed_i     (speed_i),
    .std_hcnt_i  (std_hcnt_i),
    .std_lcnt_i  (std_lcnt_i),
    .fast_hcnt_i (fast_hcnt_i),
    .fast_lcnt_i (fast_lcnt_i),
    .setup_i     (setup_i),
    .hold_i      (hold_i),
    .high_len_o  (high_len),
    .low_len_o   (low_len),
    .upd_at_o    (upd_at)
  );

  assign run   = (st_q == ST_LOW) || (st_q == ST_HIGH);
  assign clr   = !en_i || hit || !run;
  assign limit = (st_q == ST_HIGH) ? high_len : low_len;

  i2c_tgen_phase #(.CW(CW)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .run_i   (run),
    .limit_i (limit),
    .cnt_o   (cnt),
    .hit_o   (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      parked_q <= 1'b0;
    end else if (!en_i) begin
      st_q     <= ST_IDLE;
      parked_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (bit_req_i) st_q <= ST_LOW;
        ST_LOW:  if (hit) st_q <= ST_WAIT;
        // high count starts only once the line is seen released
        ST_WAIT: if (scl_seen) st_q <= ST_HIGH;
        ST_HIGH: if (hit) begin
          if (bit_req_i) st_q <= ST_LOW;
          else begin
            st_q     <= ST_IDLE;
            parked_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign scl_o      = !((st_q == ST_LOW) || ((st_q == ST_IDLE) && parked_q));
  assign sda_upd_o  = (st_q == ST_LOW) && (cnt == upd_at);
  assign bit_done_o = (st_q == ST_HIGH) && hit;
endmodule

// File: rtl/i2c_tgen_chk.sv
module i2c_tgen_chk #(
  parameter int MIN_HIGH = 6,
  parameter int MIN_LOW  = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic scl_o,
  input logic sda_upd_o,
  input logic bit_done_o
);
  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      lo_cnt <= scl_o ? '0 : ((lo_cnt == '1) ? lo_cnt : lo_cnt + 16'd1);
      hi_cnt <= !scl_o ? '0 : ((hi_cnt == '1) ? hi_cnt : hi_cnt + 16'd1);
    end
  end

  p_off_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (scl_o && !sda_upd_o && !bit_done_o));

  p_high_floor_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_done_o |-> (hi_cnt >= 16'(MIN_HIGH + 1)));

  p_low_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(scl_o) && $past(en_i)) |-> (lo_cnt >= 16'(MIN_LOW)));

  p_upd_in_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_upd_o |-> !scl_o);

  p_done_then_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_done_o && en_i) |=> !scl_o);

  p_strobe_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sda_upd_o, bit_done_o}));
endmodule

bind i2c_tgen i2c_tgen_chk #(.MIN_HIGH(MIN_HIGH), .MIN_LOW(MIN_LOW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .scl_o      (scl_o),
  .sda_upd_o  (sda_upd_o),
  .bit_done_o (bit_done_o)
);

// File: tb/tb_i2c_tgen.sv
module tb_i2c_tgen;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en = 1'b0;
  logic [2:1]    speed = 2'b01;
  logic [CW-1:0] sh = '0, sl = '0, fh = '0, fl = '0;
  logic [7:0]    su = 8'd1;
  logic [8:0]    hd = '0;
  logic          bit_req = 1'b0;
  logic          hold_low = 1'b0;
  logic          scl_i;
  logic          scl_o, sda_upd_o, bit_done_o;

  always #4 clk = ~clk;

  // wired-AND bus: an external device may hold the line low
  assign scl_i = scl_o & ~hold_low;

  i2c_tgen dut (
    .clk_i (clk), .rst_ni (rst_ni), .en_i (en), .speed_i (speed),
    .std_hcnt_i (sh), .std_lcnt_i (sl), .fast_hcnt_i (fh), .fast_lcnt_i (fl),
    .setup_i (su), .hold_i (hd), .bit_req_i (bit_req), .scl_i (scl_i),
    .scl_o (scl_o), .sda_upd_o (sda_upd_o), .bit_done_o (bit_done_o)
  );

  typedef struct {int lo; int up; int hi;} exp_t;
  exp_t  sb[$];
  int    n_chk = 0, n_err = 0;
  int    m_h, m_l, m_up;
  int    stretch_n = 0;
  string mon_tag = "R7";
  bit    finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // model from requirements R2..R7
  task automatic setcfg(input logic [2:1] sp, input int s_h, input int s_l, input int f_h,
                        input int f_l, input int st, input bit hen, input int hv);
    bit fast;
    int hs, ls, le, hh, ss, need;
    speed = sp; sh = CW'(s_h); sl = CW'(s_l); fh = CW'(f_h); fl = CW'(f_l);
    su = 8'(st); hd = {hen, 8'(hv)};
    fast = sp[2] && !sp[1];
    hs = fast ? f_h : s_h;
    ls = fast ? f_l : s_l;
    m_h = (hs < 6) ? 6 : hs;
    le = (ls < 8) ? 8 : ls;
    hh = hen ? hv + 1 : 0;
    ss = (st == 0) ? 0 : st - 1;
    need = hh + ss + 1;
    m_l = (le > need) ? le : need;
    m_up = hh;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  task automatic burst(input int n, input int nstr, input string tag);
    int k;
    stretch_n = nstr;
    mon_tag = tag;
    for (int i = 0; i < n; i++) sb.push_back('{m_l, m_up, m_h + 2 + nstr});
    k = 0;
    bit_req = 1'b1;
    while (k < n) begin
      @(negedge clk);
      if (bit_done_o) k++;
    end
    bit_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(scl_o == 1'b0, "R11 parked low after last bit", scl_o, 0);
    chk(sb.size() == 0, "R9 one bit-done per requested bit", sb.size(), 0);
    en = 1'b0;
    @(negedge clk);
    chk(scl_o == 1'b1, "R1 release on disable", scl_o, 1);
  endtask

  // bus model: hold SCL low for stretch_n cycles after each release
  int  sc = 0;
  bit  pv_s = 1'b1;
  initial forever begin
    @(negedge clk);
    if (scl_o && !pv_s) sc = stretch_n;
    hold_low = (sc > 0);
    if (sc > 0) sc--;
    pv_s = scl_o;
  end

  // monitor: compares observed phases with scoreboard items
  int lo = 0, hi = 0, up = -1;
  bit pv = 1'b1;
  initial forever begin
    @(negedge clk);
    if (!scl_o) begin
      if (pv) begin lo = 0; up = -1; end
      if (sda_upd_o) up = lo;
      lo++;
      hi = 0;
    end else begin
      if (!pv && sb.size() > 0) begin
        chk(lo == sb[0].lo, {mon_tag, " low phase length"}, lo, sb[0].lo);
        chk(up == sb[0].up, {mon_tag, " SDA strobe index"}, up, sb[0].up);
      end
      hi++;
    end
    if (bit_done_o) begin
      if (sb.size() == 0) chk(1'b0, "R9 unexpected bit-done", 1, 0);
      else begin
        chk(hi == sb[0].hi, {mon_tag, " high phase length"}, hi, sb[0].hi);
        void'(sb.pop_front());
      end
    end
    pv = scl_o;
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    chk(scl_o == 1'b1 && !sda_upd_o && !bit_done_o, "R1 reset outputs", {scl_o, sda_upd_o, bit_done_o}, 3'b100);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(scl_o == 1'b1, "R1 idle after reset", scl_o, 1);

    // R2 standard, R5 hold enabled, R9 back-to-back bits
    setcfg(2'b01, 10, 12, 20, 30, 3, 1'b1, 2);
    burst(3, 0, "R5");
    // R2 fast, R6 hold disabled with nonzero count
    setcfg(2'b10, 10, 12, 20, 30, 3, 1'b0, 5);
    burst(2, 0, "R6");
    // R2 both bits set -> standard
    setcfg(2'b11, 11, 13, 20, 30, 2, 1'b1, 1);
    burst(1, 0, "R2");
    // R3/R4 clamps, speed 00 -> standard
    setcfg(2'b00, 2, 3, 20, 30, 1, 1'b0, 0);
    burst(2, 0, "R3");
    setcfg(2'b10, 50, 50, 1, 0, 1, 1'b0, 0);
    burst(1, 0, "R4");
    // R7 low phase extended by hold plus setup
    setcfg(2'b01, 7, 9, 20, 30, 20, 1'b1, 4);
    burst(2, 0, "R7");
    // R7 setup 0 treated as 1
    setcfg(2'b01, 7, 8, 20, 30, 0, 1'b1, 10);
    burst(1, 0, "R7");
    // R8 clock stretching
    setcfg(2'b01, 9, 10, 20, 30, 2, 1'b1, 1);
    burst(2, 5, "R8");
    // R10 changes while enabled are ignored
    setcfg(2'b01, 10, 12, 20, 30, 3, 1'b1, 2);
    sh = 16'd30; sl = 16'd40; su = 8'd9; hd = 9'h000; speed = 2'b10;
    burst(2, 0, "R10");
    setcfg(2'b10, 30, 40, 25, 35, 9, 1'b0, 0);
    burst(1, 0, "R10");

    // R1 abort mid-bit and ignore requests while disabled
    setcfg(2'b01, 10, 12, 20, 30, 3, 1'b1, 2);
    bit_req = 1'b1;
    repeat (4) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(scl_o == 1'b1, "R1 abort releases SCL", scl_o, 1);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!scl_o || sda_upd_o || bit_done_o) bad++;
    end
    chk(bad == 0, "R1 request ignored while disabled", bad, 0);
    bit_req = 1'b0;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule